// File: doc/BRIEF.md
# Boundary Scan Test Port Controller

This block is the test-port front end of a chip. It runs only on the test clock, which is independent of any system clock. A serial mode-select line steps a sixteen-state controller through its capture, shift, pause and update phases. A 4-bit instruction register decides two things: which data register is connected between the serial input and the serial output, and how the boundary cells at the pins are steered.

The data paths inside the block are a one-bit bypass stage, a 32-bit identification register and a one-bit self-test result stage. The identification register captures either a fixed code or a programmable user code. The boundary register itself lives outside the block. The block drives its capture, shift and update strobes and reads its serial output back. The self-test engine is also outside. The block gives it a start pulse and captures its pass bit.

An active-low asynchronous reset forces the controller back to its reset state. Holding mode-select high for five clocks does the same.

Top module: `tapc_top`

## Requirements
- R1: The controller follows the standard sixteen-state graph, sampled on the rising test clock. `trst_n` low immediately forces the reset state, and so do five rising edges with `tms` high from any state. Either way, the active instruction returns to IDCODE and the pins return to functional mode, with `pin_scan` and `pin_hiz` both 0.
- R2: In the reset state the active instruction becomes IDCODE (code 0010). Once reset ends, a data scan with no instruction load returns the identification value.
- R3: On Capture-IR the instruction shift stage loads 0001. That pattern is shifted out least significant bit first.
- R4: Instruction bits enter at the most significant end from `tdi`. The shifted value becomes the active instruction only on the rising edge that leaves Update-IR. Until then the pin controls keep their old values.
- R5: Under IDCODE (0010), Capture-DR loads the fixed 32-bit `ID_VALUE`. It is shifted out least significant bit first.
- R6: Under USERCODE (0011), Capture-DR loads the `user_code` input into the identification register instead of the fixed value.
- R7: Under BYPASS (1111) and under any unassigned code (for example 1010), only the one-bit stage lies between `tdi` and `tdo`. That stage captures 0, so the output is the input delayed by one bit. The pins stay functional.
- R8: Under CLAMP (0110), `pin_scan` is 1 and `pin_hiz` is 0, while the bypass stage is the scan path.
- R9: Under HIGHZ (0111), `pin_hiz` is 1 and `pin_scan` is 0, while the bypass stage is the scan path.
- R10: SAMPLE/PRELOAD (0001), EXTEST (0000) and INTEST (0100) select the boundary register. `bsr_select` is 1, the strobes `bsr_capture`, `bsr_shift` and `bsr_update` are 1 in Capture-DR, Shift-DR and Update-DR respectively, and `tdo` carries `bsr_tdo`. `pin_scan` is 0 under SAMPLE/PRELOAD and 1 under EXTEST and INTEST. None of the strobes is ever asserted while another register is selected.
- R11: Under RUNBIST (0101), `pin_scan` is 1 and `bist_start` is a single-cycle pulse on the first cycle in Run-Test/Idle. Capture-DR then loads `bist_pass` into the one-bit result stage, which is shifted out.
- R12: `tdo` and `tdo_oe` change only on the falling test clock edge. `tdo_oe` is 1 only in Shift-IR and Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low controller reset |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data and instruction input |
| user_code | input | 32 | Programmable code captured under USERCODE |
| bsr_tdo | input | 1 | Serial output of the external boundary register |
| bist_pass | input | 1 | Self-test result from the external engine |
| tdo | output | 1 | Serial output, updated on the falling edge |
| tdo_oe | output | 1 | Output enable for `tdo`; 0 means high impedance |
| pin_scan | output | 1 | 1: pins are driven from the boundary register |
| pin_hiz | output | 1 | 1: all component outputs are high impedance |
| bsr_select | output | 1 | Boundary register is the selected data register |
| bsr_capture | output | 1 | Boundary capture strobe (Capture-DR) |
| bsr_shift | output | 1 | Boundary shift strobe (Shift-DR) |
| bsr_update | output | 1 | Boundary update strobe (Update-DR) |
| bist_start | output | 1 | One-cycle self-test start pulse |

## Verification
The hardest case to reach from the ports is an asynchronous reset that arrives mid-shift while a pin-driving instruction is active. It must drop `pin_scan` and `tdo_oe` between clock edges, without waiting for an edge. The bench gets there in three steps: it loads CLAMP, walks into Shift-DR, and then pulls `trst_n` low halfway through a clock phase. It samples one time unit later. A second path reaches the reset state through five `tms`-high clocks from Shift-DR. An identification scan then confirms that IDCODE came back without any instruction load.

// File: rtl/tapc_pkg.sv
package tapc_pkg;
  localparam int IR_W = 4;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {DR_BYPASS, DR_ID, DR_BOUND, DR_BIST} dr_sel_e;

  localparam logic [IR_W-1:0] OP_EXTEST   = 4'b0000;
  localparam logic [IR_W-1:0] OP_SAMPLE   = 4'b0001;
  localparam logic [IR_W-1:0] OP_IDCODE   = 4'b0010;
  localparam logic [IR_W-1:0] OP_USERCODE = 4'b0011;
  localparam logic [IR_W-1:0] OP_INTEST   = 4'b0100;
  localparam logic [IR_W-1:0] OP_RUNBIST  = 4'b0101;
  localparam logic [IR_W-1:0] OP_CLAMP    = 4'b0110;
  localparam logic [IR_W-1:0] OP_HIGHZ    = 4'b0111;
  localparam logic [IR_W-1:0] OP_BYPASS   = 4'b1111;
  localparam logic [IR_W-1:0] IR_CAP_PAT  = 4'b0001;

  typedef struct packed {
    dr_sel_e dr;
    logic    id_user;
    logic    pin_scan;
    logic    pin_hiz;
    logic    bist;
  } dec_t;

  function automatic tap_state_e tap_next(input tap_state_e s, input logic tms);
    tap_state_e n;
    case (s)
      ST_TLR:    n = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    n = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: n = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: n = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  n = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: n = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: n = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: n = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: n = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: n = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: n = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  n = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: n = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: n = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: n = tms ? ST_UPD_IR : ST_SH_IR;
      default:   n = tms ? ST_SEL_DR : ST_RTI;
    endcase
    return n;
  endfunction

  function automatic dec_t decode_op(input logic [IR_W-1:0] op, input logic has_id);
    dec_t d;
    d.dr       = DR_BYPASS;
    d.id_user  = 1'b0;
    d.pin_scan = 1'b0;
    d.pin_hiz  = 1'b0;
    d.bist     = 1'b0;
    case (op)
      OP_EXTEST, OP_INTEST: begin d.dr = DR_BOUND; d.pin_scan = 1'b1; end
      OP_SAMPLE:            d.dr = DR_BOUND;
      OP_IDCODE:            if (has_id) d.dr = DR_ID;
      OP_USERCODE:          if (has_id) begin d.dr = DR_ID; d.id_user = 1'b1; end
      OP_RUNBIST:           begin d.dr = DR_BIST; d.pin_scan = 1'b1; d.bist = 1'b1; end
      OP_CLAMP:             d.pin_scan = 1'b1;
      OP_HIGHZ:             d.pin_hiz = 1'b1;
      default:              d.dr = DR_BYPASS;
    endcase
    return d;
  endfunction

  function automatic logic [IR_W-1:0] reset_op(input logic has_id);
    return has_id ? OP_IDCODE : OP_BYPASS;
  endfunction
endpackage

// File: rtl/tapc_fsm.sv
module tapc_fsm
  import tapc_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state,
  output tap_state_e prev_state
);
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      state      <= ST_TLR;
      prev_state <= ST_TLR;
    end else begin
      prev_state <= state;
      state      <= tap_next(state, tms);
    end
  end
endmodule

// File: rtl/tapc_ir.sv
module tapc_ir
  import tapc_pkg::*;
#(
  parameter bit HAS_ID = 1'b1
) (
  input  logic            tck,
  input  logic            trst_n,
  input  tap_state_e      state,
  input  logic            tdi,
  output logic [IR_W-1:0] ir_sr,
  output logic [IR_W-1:0] ir_q
);
  localparam logic [IR_W-1:0] RST_OP = reset_op(HAS_ID);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sr <= IR_CAP_PAT;
      ir_q  <= RST_OP;
    end else begin
      case (state)
        ST_CAP_IR: ir_sr <= IR_CAP_PAT;
        ST_SH_IR:  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
        default:   ir_sr <= ir_sr;
      endcase
      if (state == ST_TLR)         ir_q <= RST_OP;
      else if (state == ST_UPD_IR) ir_q <= ir_sr;
    end
  end
endmodule

// File: rtl/tapc_dr.sv
module tapc_dr
  import tapc_pkg::*;
#(
  parameter bit          HAS_ID   = 1'b1,
  parameter int          ID_W     = 32,
  parameter logic [31:0] ID_VALUE = 32'h1C3E_5A6B
) (
  input  logic            tck,
  input  logic            trst_n,
  input  tap_state_e      state,
  input  dr_sel_e         dr_sel,
  input  logic            id_user,
  input  logic            tdi,
  input  logic [ID_W-1:0] user_code,
  input  logic            bist_pass,
  output logic            byp_out,
  output logic            id_out,
  output logic            bist_out
);
  logic cap_w, sh_w;
  assign cap_w = (state == ST_CAP_DR);
  assign sh_w  = (state == ST_SH_DR);

  logic byp_q;
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                            byp_q <= 1'b0;
    else if (cap_w && dr_sel == DR_BYPASS)  byp_q <= 1'b0;
    else if (sh_w && dr_sel == DR_BYPASS)   byp_q <= tdi;
  end
  assign byp_out = byp_q;

  logic bist_q;
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                          bist_q <= 1'b0;
    else if (cap_w && dr_sel == DR_BIST)  bist_q <= bist_pass;
    else if (sh_w && dr_sel == DR_BIST)   bist_q <= tdi;
  end
  assign bist_out = bist_q;

  generate
    if (HAS_ID) begin : g_id
      logic [ID_W-1:0] id_sr;
      always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                      id_sr <= ID_VALUE[ID_W-1:0];
        else if (cap_w && dr_sel == DR_ID) id_sr <= id_user ? user_code : ID_VALUE[ID_W-1:0];
        else if (sh_w && dr_sel == DR_ID)  id_sr <= {tdi, id_sr[ID_W-1:1]};
      end
      assign id_out = id_sr[0];
    end else begin : g_no_id
      assign id_out = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/tapc_top.sv
module tapc_top
  import tapc_pkg::*;
#(
  parameter bit          HAS_ID   = 1'b1,
  parameter int          ID_W     = 32,
  parameter logic [31:0] ID_VALUE = 32'h1C3E_5A6B
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tms,
  input  logic            tdi,
  input  logic [ID_W-1:0] user_code,
  input  logic            bsr_tdo,
  input  logic            bist_pass,
  output logic            tdo,
  output logic            tdo_oe,
  output logic            pin_scan,
  output logic            pin_hiz,
  output logic            bsr_select,
  output logic            bsr_capture,
  output logic            bsr_shift,
  output logic            bsr_update,
  output logic            bist_start
);
  tap_state_e      state, prev_state;
  logic [IR_W-1:0] ir_sr, ir_q;
  dec_t            dec;
  logic            byp_out, id_out, bist_out;

  // named internal events for the checker
  logic in_tlr, in_rti, in_sh_ir, in_sh_dr, upd_ir_w, cap_ir_w;
  logic tdo_next, oe_next;

  tapc_fsm u_fsm (
    .tck(tck), .trst_n(trst_n), .tms(tms),
    .state(state), .prev_state(prev_state)
  );

  tapc_ir #(.HAS_ID(HAS_ID)) u_ir (
    .tck(tck), .trst_n(trst_n), .state(state), .tdi(tdi),
    .ir_sr(ir_sr), .ir_q(ir_q)
  );

  assign dec = decode_op(ir_q, HAS_ID);

  tapc_dr #(.HAS_ID(HAS_ID), .ID_W(ID_W), .ID_VALUE(ID_VALUE)) u_dr (
    .tck(tck), .trst_n(trst_n), .state(state), .dr_sel(dec.dr),
    .id_user(dec.id_user), .tdi(tdi), .user_code(user_code),
    .bist_pass(bist_pass), .byp_out(byp_out), .id_out(id_out),
    .bist_out(bist_out)
  );

  assign in_tlr   = (state == ST_TLR);
  assign in_rti   = (state == ST_RTI);
  assign in_sh_ir = (state == ST_SH_IR);
  assign in_sh_dr = (state == ST_SH_DR);
  assign upd_ir_w = (state == ST_UPD_IR);
  assign cap_ir_w = (state == ST_CAP_IR);

  assign pin_scan    = dec.pin_scan && !in_tlr;
  assign pin_hiz     = dec.pin_hiz && !in_tlr;
  assign bsr_select  = (dec.dr == DR_BOUND);
  assign bsr_capture = bsr_select && (state == ST_CAP_DR);
  assign bsr_shift   = bsr_select && in_sh_dr;
  assign bsr_update  = bsr_select && (state == ST_UPD_DR);
  assign bist_start  = dec.bist && in_rti && (prev_state != ST_RTI);

  always_comb begin
    tdo_next = 1'b0;
    if (in_sh_ir) tdo_next = ir_sr[0];
    else if (in_sh_dr) begin
      case (dec.dr)
        DR_ID:    tdo_next = id_out;
        DR_BOUND: tdo_next = bsr_tdo;
        DR_BIST:  tdo_next = bist_out;
        default:  tdo_next = byp_out;
      endcase
    end
  end
  assign oe_next = in_sh_ir || in_sh_dr;

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= tdo_next;
      tdo_oe <= oe_next;
    end
  end
endmodule

// File: rtl/tapc_chk.sv
module tapc_chk
  import tapc_pkg::*;
#(
  parameter bit HAS_ID = 1'b1
) (
  input logic            tck,
  input logic            trst_n,
  input logic            tms,
  input logic            in_tlr,
  input logic            in_sh_ir,
  input logic            in_sh_dr,
  input logic            upd_ir_w,
  input logic            cap_ir_w,
  input logic [IR_W-1:0] ir_sr,
  input logic [IR_W-1:0] ir_q,
  input logic            tdo_oe,
  input logic            pin_scan,
  input logic            pin_hiz,
  input logic            bsr_select,
  input logic            bsr_capture,
  input logic            bsr_shift,
  input logic            bsr_update,
  input logic            bist_start
);
  // R1
  tlr_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
    in_tlr && tms |=> in_tlr);
  // R2
  tlr_default_chk: assert property (@(posedge tck) disable iff (!trst_n)
    in_tlr |=> (ir_q == reset_op(HAS_ID)));
  // R3
  cap_ir_chk: assert property (@(posedge tck) disable iff (!trst_n)
    cap_ir_w |=> (ir_sr == IR_CAP_PAT));
  // R4
  ir_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
    !upd_ir_w && !in_tlr |=> $stable(ir_q));
  // R9
  hiz_excl_chk: assert property (@(posedge tck) disable iff (!trst_n)
    !(pin_hiz && pin_scan));
  // R10
  bsr_strobe_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (bsr_capture || bsr_shift || bsr_update) |-> bsr_select);
  // R10
  bsr_onehot_chk: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0({bsr_capture, bsr_shift, bsr_update}));
  // R11
  bist_pulse_chk: assert property (@(posedge tck) disable iff (!trst_n)
    bist_start |=> !bist_start);
  // R12
  tdo_oe_chk: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe |-> (in_sh_ir || in_sh_dr));
endmodule

bind tapc_top tapc_chk #(.HAS_ID(HAS_ID)) u_chk (
  .tck(tck), .trst_n(trst_n), .tms(tms), .in_tlr(in_tlr),
  .in_sh_ir(in_sh_ir), .in_sh_dr(in_sh_dr), .upd_ir_w(upd_ir_w),
  .cap_ir_w(cap_ir_w), .ir_sr(ir_sr), .ir_q(ir_q), .tdo_oe(tdo_oe),
  .pin_scan(pin_scan), .pin_hiz(pin_hiz), .bsr_select(bsr_select),
  .bsr_capture(bsr_capture), .bsr_shift(bsr_shift),
  .bsr_update(bsr_update), .bist_start(bist_start)
);

// File: tb/tapc_top_bench.sv
module tapc_top_bench;
  localparam logic [31:0] EXP_ID = 32'h1C3E_5A6B;

  logic tck = 1'b0;
  logic trst_n = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic [31:0] user_code = 32'h0;
  logic bsr_tdo = 1'b0;
  logic bist_pass = 1'b0;
  logic tdo, tdo_oe, pin_scan, pin_hiz, bsr_select, bsr_capture, bsr_shift, bsr_update, bist_start;

  int checks = 0;
  int failures = 0;
  int cap_cnt = 0, sh_cnt = 0, upd_cnt = 0;
  bit done = 1'b0;

  always #4 tck = ~tck;

  tapc_top u_tapc_top (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .user_code(user_code),
    .bsr_tdo(bsr_tdo), .bist_pass(bist_pass), .tdo(tdo), .tdo_oe(tdo_oe),
    .pin_scan(pin_scan), .pin_hiz(pin_hiz), .bsr_select(bsr_select),
    .bsr_capture(bsr_capture), .bsr_shift(bsr_shift), .bsr_update(bsr_update),
    .bist_start(bist_start)
  );

  always @(negedge tck) begin
    if (bsr_capture) cap_cnt++;
    if (bsr_shift)   sh_cnt++;
    if (bsr_update)  upd_cnt++;
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck); @(negedge tck); #1;
  endtask

  task automatic shift_bits(input int n, input logic [63:0] din, output logic [63:0] dout);
    dout = '0;
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      step(i == n - 1, din[i]);
    end
  endtask

  task automatic load_ir(input logic [3:0] code, output logic [3:0] cap);
    logic [63:0] o;
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    shift_bits(4, {60'h0, code}, o);
    cap = o[3:0];
    step(1, 0); step(0, 0);
  endtask

  task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
    step(1, 0); step(0, 0); step(0, 0);
    shift_bits(n, din, dout);
    step(1, 0); step(0, 0);
  endtask

  task automatic t_reset;
    logic [63:0] o;
    check(tdo_oe == 0 && pin_scan == 0 && pin_hiz == 0 && bist_start == 0,
          "R2 reset outputs", {tdo_oe, pin_scan, pin_hiz, bist_start}, 0);
    trst_n = 1'b1;
    step(0, 0);
    scan_dr(32, 64'h0, o);
    check(o[31:0] == EXP_ID, "R2 R5 idcode after reset", o[31:0], EXP_ID);
  endtask

  task automatic t_ir_timing;
    logic [63:0] o;
    step(1, 0); step(1, 0); step(0, 0);
    tms = 0;
    @(posedge tck); #1;
    check(tdo_oe == 0, "R12 oe before falling edge", tdo_oe, 0);
    @(negedge tck); #1;
    check(tdo_oe == 1, "R12 oe in Shift-IR", tdo_oe, 1);
    shift_bits(4, 64'h6, o);
    check(o[3:0] == 4'b0001, "R3 capture pattern", o[3:0], 4'b0001);
    check(tdo_oe == 0, "R12 oe off in Exit1-IR", tdo_oe, 0);
    check(pin_scan == 0, "R4 no effect before update", pin_scan, 0);
    step(1, 0);
    check(pin_scan == 0, "R4 no effect in Update-IR", pin_scan, 0);
    step(0, 0);
    check(pin_scan == 1 && pin_hiz == 0, "R8 clamp pins", {pin_scan, pin_hiz}, 2'b10);
    scan_dr(8, 64'hB2, o);
    check(o[7:0] == 8'h64, "R8 clamp bypass path", o[7:0], 8'h64);
  endtask

  task automatic t_trst;
    logic [63:0] o;
    step(1, 0); step(0, 0); step(0, 0);
    check(tdo_oe == 1, "R12 oe in Shift-DR", tdo_oe, 1);
    #1 trst_n = 1'b0;
    #1;
    check(pin_scan == 0 && tdo_oe == 0, "R1 async reset", {pin_scan, tdo_oe}, 0);
    @(posedge tck); #1 trst_n = 1'b1;
    @(negedge tck); #1;
    step(0, 0);
    scan_dr(32, 64'h0, o);
    check(o[31:0] == EXP_ID, "R1 R2 idcode after trst", o[31:0], EXP_ID);
  endtask

  task automatic t_tms_reset;
    logic [3:0] c;
    logic [63:0] o;
    load_ir(4'b0110, c);
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 5; i++) step(1, 0);
    check(pin_scan == 0, "R1 five tms ones", pin_scan, 0);
    step(0, 0);
    scan_dr(32, 64'h0, o);
    check(o[31:0] == EXP_ID, "R1 idcode after tms reset", o[31:0], EXP_ID);
  endtask

  task automatic t_usercode;
    logic [3:0] c;
    logic [63:0] o;
    user_code = 32'hCAFE_0123;
    load_ir(4'b0011, c);
    scan_dr(32, 64'h0, o);
    check(o[31:0] == 32'hCAFE_0123, "R6 usercode", o[31:0], 32'hCAFE_0123);
  endtask

  task automatic t_bypass(input logic [3:0] code);
    logic [3:0] c;
    logic [63:0] o;
    load_ir(code, c);
    cap_cnt = 0; sh_cnt = 0; upd_cnt = 0;
    scan_dr(8, 64'hB2, o);
    check(o[7:0] == 8'h64, "R7 one-bit delay", o[7:0], 8'h64);
    check(pin_scan == 0 && pin_hiz == 0, "R7 pins functional", {pin_scan, pin_hiz}, 0);
    check(cap_cnt + sh_cnt + upd_cnt == 0, "R10 no strobes off boundary", cap_cnt + sh_cnt + upd_cnt, 0);
  endtask

  task automatic t_highz;
    logic [3:0] c;
    logic [63:0] o;
    load_ir(4'b0111, c);
    check(pin_hiz == 1 && pin_scan == 0, "R9 highz pins", {pin_hiz, pin_scan}, 2'b10);
    scan_dr(6, 64'h2D, o);
    check(o[5:0] == 6'h1A, "R9 bypass path", o[5:0], 6'h1A);
  endtask

  task automatic t_boundary(input logic [3:0] code, input logic exp_scan);
    logic [3:0] c;
    load_ir(code, c);
    check(pin_scan == exp_scan && bsr_select == 1, "R10 boundary mode pins",
          {pin_scan, bsr_select}, {exp_scan, 1'b1});
    cap_cnt = 0; sh_cnt = 0; upd_cnt = 0;
    bsr_tdo = 1'b1;
    step(1, 0); step(0, 0); step(0, 0);
    check(tdo == 1 && bsr_shift == 1, "R10 tdo follows boundary 1", {tdo, bsr_shift}, 2'b11);
    bsr_tdo = 1'b0;
    step(0, 0);
    check(tdo == 0, "R10 tdo follows boundary 0", tdo, 0);
    step(1, 0); step(1, 0); step(0, 0);
    check(cap_cnt == 1 && sh_cnt == 2 && upd_cnt == 1, "R10 strobe counts",
          {cap_cnt[15:0], sh_cnt[15:0], upd_cnt[15:0]}, {16'd1, 16'd2, 16'd1});
  endtask

  task automatic t_runbist;
    logic [3:0] c;
    logic [63:0] o;
    load_ir(4'b0101, c);
    check(bist_start == 1 && pin_scan == 1, "R11 start pulse", {bist_start, pin_scan}, 2'b11);
    step(0, 0);
    check(bist_start == 0, "R11 single pulse", bist_start, 0);
    bist_pass = 1'b1;
    scan_dr(1, 64'h0, o);
    check(o[0] == 1, "R11 result pass", o[0], 1);
    bist_pass = 1'b0;
    scan_dr(1, 64'h0, o);
    check(o[0] == 0, "R11 result fail", o[0], 0);
  endtask

  initial begin
    #20;
    t_reset();
    t_ir_timing();
    t_trst();
    t_tms_reset();
    t_usercode();
    t_bypass(4'b1111);
    t_bypass(4'b1010);
    t_highz();
    t_boundary(4'b0001, 1'b0);
    t_boundary(4'b0000, 1'b1);
    t_boundary(4'b0100, 1'b1);
    t_runbist();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule